// File: doc/BRIEF.md
# Raster Timing Generator

This block produces the horizontal and vertical raster timing of a display controller. A horizontal counter advances once per clock, where each clock is one character cell of 8 pixels. A vertical counter advances once per completed line. From these two positions and a set of timing fields, the block drives horizontal and vertical sync, horizontal and vertical blank, a display-enable strobe and the current scanline number. Software can poll the scanline number, for example to wait until the raster has left the visible area.

The timing fields are loaded through a one-cycle write port into a shadow set, and the shadow set is copied into the working set only at the edge where a frame ends. A frame therefore never runs with mixed old and new timing. The totals and display ends are stored with fixed offsets. Sync and blank ends are short fields, and they are compared only against the low bits of the running counter. A mode field sets the sync polarity. It can also silence either sync or blank the whole screen, which covers power-saving states.

Top module: `crtc_raster_gen`

## Requirements
- R1: A line lasts (line-total field + 5) clocks and a frame lasts (frame-total field + 2) lines. The vertical counter advances only on the last clock of a line, both counters return to 0 after their last value, and `scanline` shows the 11-bit line number.
- R2: `display_en` is 1 exactly when the character count is at or below the horizontal display-end field and the line number is at or below the vertical display-end field, unless the screen-off bit is set.
- R3: Horizontal sync is active from the count equal to the sync-start field. It ends at the first later count whose low 5 bits equal the 5-bit sync-end field, so its width is (end - start) mod 32, where 0 means 32.
- R4: Vertical sync is active from the line equal to its start field. It ends at the first later line whose low 4 bits equal the 4-bit end field, so its width is (end - start) mod 16 lines, where 0 means 16.
- R5: Horizontal blank is active from the count equal to the display-end field + 1, through and including the first such or later count whose low 7 bits equal the 7-bit blank-end field.
- R6: Vertical blank is active from the line equal to the display-end field + 1, through and including the first such or later line whose low 8 bits equal the 8-bit blank-end field.
- R7: Mode bit 0 inverts `hsync` and mode bit 1 inverts `vsync`. When a bit is 0, its sync output is active high.
- R8: Mode bit 2 holds `hsync` and mode bit 3 holds `vsync` at their inactive level, whatever the raster position.
- R9: Mode bit 4 (screen off) holds `hblank` and `vblank` at 1 and `display_en` at 0.
- R10: A write changes only the shadow set. The running frame keeps its timing, and the new values apply from count 0 of the next frame.
- R11: While reset is held, both counters are 0 and the built-in timing applies (20-clock lines, 10-line frames, display ends 9 and 5, mode 0). `scanline` reads 0, both syncs and both blanks read 0, and `display_en` reads 1.
- R12: Register addresses are: 0 line total, 1 horizontal display end, 2 horizontal sync start, 3 horizontal sync end, 4 horizontal blank end, 5 frame total, 6 vertical display end, 7 vertical sync start, 8 vertical sync end, 9 vertical blank end, 10 mode. Each field takes the low bits of `wr_data`. Writes to addresses 11 to 15 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the shadow register set |
| wr_addr | input | 4 | Register address |
| wr_data | input | 11 | Write data; each field takes its low bits |
| hsync | output | 1 | Horizontal sync after polarity and disable |
| vsync | output | 1 | Vertical sync after polarity and disable |
| hblank | output | 1 | Horizontal blank |
| vblank | output | 1 | Vertical blank |
| display_en | output | 1 | Visible-area strobe |
| scanline | output | 11 | Current line number |

## Verification
Every output is decoded directly from registered counter and flag state. A result therefore belongs to the clock in which the counters hold that position, and the bench samples it on the falling edge of the same clock. The bench runs its own character and line position from the release of reset, stepping it once per clock. It holds the timing that should be in force at each moment, so no waiting or realignment is needed. Writes are issued one per clock during the first cycles of a frame. The rest of that frame is checked against the old timing, and the following frame, from its count 0, against the new timing. This pins down the one-frame latency of R10 exactly.

// File: rtl/crtc_pkg.sv
`timescale 1ns/1ps
package crtc_pkg;

    localparam int HREG_W  = 9;
    localparam int VREG_W  = 11;
    localparam int HSE_W   = 5;
    localparam int VSE_W   = 4;
    localparam int HBE_W   = 7;
    localparam int VBE_W   = 8;
    localparam int ADDR_W  = 4;
    localparam int DATA_W  = VREG_W;
    localparam int LINE_W  = 11;
    localparam int HCNT_W  = HREG_W + 1;
    localparam int VCNT_W  = VREG_W + 1;
    localparam int H_OFS   = 5;
    localparam int V_OFS   = 2;

    typedef enum logic [ADDR_W-1:0] {
        ADDR_HTOT  = 4'd0,
        ADDR_HDEND = 4'd1,
        ADDR_HSBEG = 4'd2,
        ADDR_HSEND = 4'd3,
        ADDR_HBEND = 4'd4,
        ADDR_VTOT  = 4'd5,
        ADDR_VDEND = 4'd6,
        ADDR_VSBEG = 4'd7,
        ADDR_VSEND = 4'd8,
        ADDR_VBEND = 4'd9,
        ADDR_MODE  = 4'd10
    } crtc_addr_e;

    typedef struct packed {
        logic blank_all;
        logic vs_off;
        logic hs_off;
        logic vs_inv;
        logic hs_inv;
    } crtc_mode_t;

    localparam int MODE_W = $bits(crtc_mode_t);

    typedef struct packed {
        logic [HREG_W-1:0] h_total;
        logic [HREG_W-1:0] h_disp_end;
        logic [HREG_W-1:0] h_sync_beg;
        logic [HSE_W-1:0]  h_sync_end;
        logic [HBE_W-1:0]  h_blank_end;
        logic [VREG_W-1:0] v_total;
        logic [VREG_W-1:0] v_disp_end;
        logic [VREG_W-1:0] v_sync_beg;
        logic [VSE_W-1:0]  v_sync_end;
        logic [VBE_W-1:0]  v_blank_end;
        crtc_mode_t        mode;
    } crtc_cfg_t;

    function automatic crtc_cfg_t cfg_default();
        crtc_cfg_t c;
        c.h_total     = HREG_W'(15);
        c.h_disp_end  = HREG_W'(9);
        c.h_sync_beg  = HREG_W'(12);
        c.h_sync_end  = HSE_W'(16);
        c.h_blank_end = HBE_W'(19);
        c.v_total     = VREG_W'(8);
        c.v_disp_end  = VREG_W'(5);
        c.v_sync_beg  = VREG_W'(7);
        c.v_sync_end  = VSE_W'(9);
        c.v_blank_end = VBE_W'(9);
        c.mode        = '0;
        return c;
    endfunction

    function automatic logic [HCNT_W-1:0] h_last(input logic [HREG_W-1:0] tot);
        return HCNT_W'(tot) + HCNT_W'(H_OFS - 1);
    endfunction

    function automatic logic [VCNT_W-1:0] v_last(input logic [VREG_W-1:0] tot);
        return VCNT_W'(tot) + VCNT_W'(V_OFS - 1);
    endfunction

endpackage

// File: rtl/crtc_span_flag.sv
`timescale 1ns/1ps
module crtc_span_flag (
    input  logic clk,
    input  logic rst,
    input  logic step,
    input  logic start_hit,
    input  logic stop_hit,
    output logic active
);
    // Start wins over stop; stop only clears a flag that is already set.
    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
        end else if (step) begin
            if (start_hit)
                active <= 1'b1;
            else if (active && stop_hit)
                active <= 1'b0;
        end
    end
endmodule

// File: rtl/crtc_regfile.sv
`timescale 1ns/1ps
module crtc_regfile
    import crtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              frame_end,
    output crtc_cfg_t         cfg
);
    crtc_cfg_t shadow;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow <= cfg_default();
        end else if (wr_en) begin
            case (wr_addr)
                ADDR_HTOT:  shadow.h_total     <= wr_data[HREG_W-1:0];
                ADDR_HDEND: shadow.h_disp_end  <= wr_data[HREG_W-1:0];
                ADDR_HSBEG: shadow.h_sync_beg  <= wr_data[HREG_W-1:0];
                ADDR_HSEND: shadow.h_sync_end  <= wr_data[HSE_W-1:0];
                ADDR_HBEND: shadow.h_blank_end <= wr_data[HBE_W-1:0];
                ADDR_VTOT:  shadow.v_total     <= wr_data[VREG_W-1:0];
                ADDR_VDEND: shadow.v_disp_end  <= wr_data[VREG_W-1:0];
                ADDR_VSBEG: shadow.v_sync_beg  <= wr_data[VREG_W-1:0];
                ADDR_VSEND: shadow.v_sync_end  <= wr_data[VSE_W-1:0];
                ADDR_VBEND: shadow.v_blank_end <= wr_data[VBE_W-1:0];
                ADDR_MODE:  shadow.mode        <= wr_data[MODE_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            cfg <= cfg_default();
        else if (frame_end)
            cfg <= shadow;
    end

    // R10: working timing only moves on the frame boundary
    assert_load_at_frame_R10: assert property (@(posedge clk) disable iff (rst)
        !$past(frame_end) |-> $stable(cfg))
        else $error("working timing changed inside a frame");

endmodule

// File: rtl/crtc_hcount.sv
`timescale 1ns/1ps
module crtc_hcount
    import crtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [HREG_W-1:0] h_total,
    input  logic [HREG_W-1:0] h_disp_end,
    input  logic [HREG_W-1:0] h_sync_beg,
    input  logic [HSE_W-1:0]  h_sync_end,
    input  logic [HBE_W-1:0]  h_blank_end,
    output logic [HCNT_W-1:0] hcnt,
    output logic              line_end,
    output logic              hs_act,
    output logic              hb_act,
    output logic              h_vis
);
    logic [HCNT_W-1:0] hnext;
    logic [HCNT_W-1:0] hde_ext;
    logic [HCNT_W-1:0] hsb_ext;

    assign hde_ext  = HCNT_W'(h_disp_end);
    assign hsb_ext  = HCNT_W'(h_sync_beg);
    assign line_end = (hcnt == h_last(h_total));
    assign hnext    = line_end ? '0 : hcnt + HCNT_W'(1);
    assign h_vis    = (hcnt <= hde_ext);

    always_ff @(posedge clk) begin
        if (rst) hcnt <= '0;
        else     hcnt <= hnext;
    end

    // Sync: starts on the start count, ends on a low-bit match of the next count
    crtc_span_flag u_hsync (
        .clk       (clk),
        .rst       (rst),
        .step      (1'b1),
        .start_hit (hnext == hsb_ext),
        .stop_hit  (hnext[HSE_W-1:0] == h_sync_end),
        .active    (hs_act)
    );

    // Blank: starts after display end, last blank count matches the low bits
    crtc_span_flag u_hblank (
        .clk       (clk),
        .rst       (rst),
        .step      (1'b1),
        .start_hit (hnext == hde_ext + HCNT_W'(1)),
        .stop_hit  (hcnt[HBE_W-1:0] == h_blank_end),
        .active    (hb_act)
    );

    assert_line_len_R1: assert property (@(posedge clk) disable iff (rst)
        (hcnt == '0 && $past(hcnt) != '0) |-> $past(hcnt) == $past(HCNT_W'(h_total)) + HCNT_W'(4))
        else $error("line wrapped at the wrong count");

    assert_hs_rise_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(hs_act) |-> hcnt == $past(hsb_ext))
        else $error("hsync began off its start count");

    assert_hs_fall_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(hs_act) |-> hcnt[HSE_W-1:0] == $past(h_sync_end))
        else $error("hsync ended without an end-field match");

    assert_hb_fall_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(hb_act) |-> $past(hcnt[HBE_W-1:0]) == $past(h_blank_end))
        else $error("hblank ended without an end-field match");

endmodule

// File: rtl/crtc_vcount.sv
`timescale 1ns/1ps
module crtc_vcount
    import crtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              line_end,
    input  logic [VREG_W-1:0] v_total,
    input  logic [VREG_W-1:0] v_disp_end,
    input  logic [VREG_W-1:0] v_sync_beg,
    input  logic [VSE_W-1:0]  v_sync_end,
    input  logic [VBE_W-1:0]  v_blank_end,
    output logic [VCNT_W-1:0] vcnt,
    output logic              frame_end,
    output logic              vs_act,
    output logic              vb_act,
    output logic              v_vis
);
    logic              last_line;
    logic [VCNT_W-1:0] vnext;
    logic [VCNT_W-1:0] vde_ext;

    assign vde_ext   = VCNT_W'(v_disp_end);
    assign last_line = (vcnt == v_last(v_total));
    assign frame_end = line_end && last_line;
    assign vnext     = last_line ? '0 : vcnt + VCNT_W'(1);
    assign v_vis     = (vcnt <= vde_ext);

    always_ff @(posedge clk) begin
        if (rst)           vcnt <= '0;
        else if (line_end) vcnt <= vnext;
    end

    crtc_span_flag u_vsync (
        .clk       (clk),
        .rst       (rst),
        .step      (line_end),
        .start_hit (vnext == VCNT_W'(v_sync_beg)),
        .stop_hit  (vnext[VSE_W-1:0] == v_sync_end),
        .active    (vs_act)
    );

    crtc_span_flag u_vblank (
        .clk       (clk),
        .rst       (rst),
        .step      (line_end),
        .start_hit (vnext == vde_ext + VCNT_W'(1)),
        .stop_hit  (vcnt[VBE_W-1:0] == v_blank_end),
        .active    (vb_act)
    );

    assert_line_step_R1: assert property (@(posedge clk) disable iff (rst)
        !$past(line_end) |-> $stable(vcnt))
        else $error("line number moved inside a line");

    assert_vs_fall_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(vs_act) |-> vcnt[VSE_W-1:0] == $past(v_sync_end))
        else $error("vsync ended without an end-field match");

    assert_vb_fall_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(vb_act) |-> $past(vcnt[VBE_W-1:0]) == $past(v_blank_end))
        else $error("vblank ended without an end-field match");

endmodule

// File: rtl/crtc_raster_gen.sv
`timescale 1ns/1ps
module crtc_raster_gen
    import crtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              hsync,
    output logic              vsync,
    output logic              hblank,
    output logic              vblank,
    output logic              display_en,
    output logic [LINE_W-1:0] scanline
);
    crtc_cfg_t         cfg;
    logic [HCNT_W-1:0] hcnt;
    logic [VCNT_W-1:0] vcnt;
    logic              line_end, frame_end;
    logic              hs_act, hb_act, h_vis;
    logic              vs_act, vb_act, v_vis;

    crtc_regfile u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .frame_end (frame_end),
        .cfg       (cfg)
    );

    crtc_hcount u_h (
        .clk         (clk),
        .rst         (rst),
        .h_total     (cfg.h_total),
        .h_disp_end  (cfg.h_disp_end),
        .h_sync_beg  (cfg.h_sync_beg),
        .h_sync_end  (cfg.h_sync_end),
        .h_blank_end (cfg.h_blank_end),
        .hcnt        (hcnt),
        .line_end    (line_end),
        .hs_act      (hs_act),
        .hb_act      (hb_act),
        .h_vis       (h_vis)
    );

    crtc_vcount u_v (
        .clk         (clk),
        .rst         (rst),
        .line_end    (line_end),
        .v_total     (cfg.v_total),
        .v_disp_end  (cfg.v_disp_end),
        .v_sync_beg  (cfg.v_sync_beg),
        .v_sync_end  (cfg.v_sync_end),
        .v_blank_end (cfg.v_blank_end),
        .vcnt        (vcnt),
        .frame_end   (frame_end),
        .vs_act      (vs_act),
        .vb_act      (vb_act),
        .v_vis       (v_vis)
    );

    assign hsync      = (hs_act & ~cfg.mode.hs_off) ^ cfg.mode.hs_inv;
    assign vsync      = (vs_act & ~cfg.mode.vs_off) ^ cfg.mode.vs_inv;
    assign hblank     = hb_act | cfg.mode.blank_all;
    assign vblank     = vb_act | cfg.mode.blank_all;
    assign display_en = h_vis & v_vis & ~cfg.mode.blank_all;
    assign scanline   = vcnt[LINE_W-1:0];

    assert_hs_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        cfg.mode.hs_off |-> hsync == cfg.mode.hs_inv)
        else $error("hsync moved while disabled");

    assert_vs_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        cfg.mode.vs_off |-> vsync == cfg.mode.vs_inv)
        else $error("vsync moved while disabled");

    assert_screen_off_R9: assert property (@(posedge clk) disable iff (rst)
        cfg.mode.blank_all |-> (hblank && vblank && !display_en))
        else $error("screen-off did not blank");

    assert_wrap_zero_R1: assert property (@(posedge clk) disable iff (rst)
        $past(frame_end) |-> (hcnt == '0 && vcnt == '0))
        else $error("frame did not restart at the origin");

endmodule

// File: tb/sim_crtc_raster_gen.sv
`timescale 1ns/1ps
module sim_crtc_raster_gen;

    typedef struct {
        int htot, hde, hss, hse, hbe;
        int vtot, vde, vss, vse, vbe;
        int mode;
    } bcfg_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [10:0] wr_data = '0;
    logic        hsync, vsync, hblank, vblank, display_en;
    logic [10:0] scanline;

    int nchk  = 0;
    int nfail = 0;
    int cur_h = 0;
    int cur_v = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    crtc_raster_gen u0 (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .hsync      (hsync),
        .vsync      (vsync),
        .hblank     (hblank),
        .vblank     (vblank),
        .display_en (display_en),
        .scanline   (scanline)
    );

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d (h=%0d v=%0d)", tag, act, exp, cur_h, cur_v);
        end
    endtask

    // ---- expected values from the requirements ----
    function automatic bit e_hs(bcfg_t c, int h);          // R3
        int w = (c.hse - c.hss) & 31;
        if (w == 0) w = 32;
        return (h >= c.hss) && (h < c.hss + w);
    endfunction

    function automatic bit e_vs(bcfg_t c, int v);          // R4
        int w = (c.vse - c.vss) & 15;
        if (w == 0) w = 16;
        return (v >= c.vss) && (v < c.vss + w);
    endfunction

    function automatic bit e_hb(bcfg_t c, int h);          // R5
        int s = c.hde + 1;
        int e = s + ((c.hbe - s) & 127);
        return (h >= s) && (h <= e);
    endfunction

    function automatic bit e_vb(bcfg_t c, int v);          // R6
        int s = c.vde + 1;
        int e = s + ((c.vbe - s) & 255);
        return (v >= s) && (v <= e);
    endfunction

    function automatic int field_of(bcfg_t c, int a);      // R12 address map
        case (a)
            0: return c.htot;   1: return c.hde;  2: return c.hss;
            3: return c.hse;    4: return c.hbe;  5: return c.vtot;
            6: return c.vde;    7: return c.vss;  8: return c.vse;
            9: return c.vbe;    10: return c.mode;
            default: return 11'h7ff;
        endcase
    endfunction

    // Check one frame of cfg c cycle by cycle; optionally load n during it.
    task automatic run_frame(input bcfg_t c, input bcfg_t n, input bit do_wr);
        int    ht   = c.htot + 5;
        int    vt   = c.vtot + 2;
        int    idx  = 0;
        bit    off  = c.mode[4];
        string ft   = do_wr ? " R10" : "";
        for (int v = 0; v < vt; v++) begin
            for (int h = 0; h < ht; h++) begin
                cur_h = h;
                cur_v = v;
                chk({"R1 scanline", ft}, scanline, v);
                chk({"R2 R9 display_en", ft}, display_en,
                    (h <= c.hde && v <= c.vde && !off) ? 1 : 0);
                chk({"R3 R7 R8 hsync", ft}, hsync,
                    (e_hs(c, h) && !c.mode[2]) ^ c.mode[0]);
                chk({"R4 R7 R8 vsync", ft}, vsync,
                    (e_vs(c, v) && !c.mode[3]) ^ c.mode[1]);
                chk({"R5 R9 hblank", ft}, hblank, (e_hb(c, h) || off) ? 1 : 0);
                chk({"R6 R9 vblank", ft}, vblank, (e_vb(c, v) || off) ? 1 : 0);
                // writes: addresses 0..10 carry n, 11..15 carry junk (R12)
                if (do_wr && idx >= 1 && idx <= 16) begin
                    wr_en   = 1'b1;
                    wr_addr = 4'(idx - 1);
                    wr_data = 11'(field_of(n, idx - 1));
                end else begin
                    wr_en   = 1'b0;
                end
                idx++;
                @(posedge clk);
                @(negedge clk);
            end
        end
        wr_en = 1'b0;
    endtask

    function automatic bcfg_t rand_cfg();
        bcfg_t c;
        int ht, vt, w, wmax;
        ht     = 20 + int'($urandom % 21);
        c.htot = ht - 5;
        c.hde  = 3 + int'($urandom % (ht - 14));
        c.hss  = c.hde + 2 + int'($urandom % (ht - 3 - (c.hde + 2)));
        wmax   = ht - 1 - c.hss;
        if (wmax > 31) wmax = 31;
        w      = 1 + int'($urandom % wmax);
        c.hse  = (c.hss + w) & 31;
        c.hbe  = (ht - 1) & 127;
        vt     = 8 + int'($urandom % 7);
        c.vtot = vt - 2;
        c.vde  = 1 + int'($urandom % (vt - 6));
        c.vss  = c.vde + 2 + int'($urandom % (vt - 2 - (c.vde + 2)));
        wmax   = vt - 1 - c.vss;
        if (wmax > 15) wmax = 15;
        w      = 1 + int'($urandom % wmax);
        c.vse  = (c.vss + w) & 15;
        c.vbe  = (vt - 1) & 255;
        c.mode = int'($urandom % 32);
        return c;
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    initial begin : main
        bcfg_t cur, nxt;
        bcfg_t plan [4];
        void'($urandom(32'd20240611));

        cur = '{htot:15, hde:9, hss:12, hse:16, hbe:19,
                vtot:8, vde:5, vss:7, vse:9, vbe:9, mode:0};
        // wide pulses: 32-clock hsync and 16-line vsync
        plan[0] = '{htot:55, hde:15, hss:20, hse:20, hbe:59,
                    vtot:22, vde:3, vss:5, vse:5, vbe:23, mode:0};
        // both polarities inverted, hsync disabled
        plan[1] = '{htot:19, hde:7, hss:10, hse:13, hbe:23,
                    vtot:8, vde:4, vss:6, vse:8, vbe:9, mode:7};
        // screen off, short blank ends, hsync inverted
        plan[2] = '{htot:25, hde:11, hss:22, hse:27, hbe:20,
                    vtot:10, vde:5, vss:9, vse:11, vbe:8, mode:17};
        // vsync disabled at inverted level
        plan[3] = '{htot:23, hde:13, hss:16, hse:19, hbe:27,
                    vtot:9, vde:6, vss:8, vse:9, vbe:10, mode:10};

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11: state held by reset
        cur_h = 0; cur_v = 0;
        chk("R11 scanline", scanline, 0);
        chk("R11 hsync", hsync, 0);
        chk("R11 vsync", vsync, 0);
        chk("R11 hblank", hblank, 0);
        chk("R11 vblank", vblank, 0);
        chk("R11 display_en", display_en, 1);
        rst = 1'b0;

        for (int i = 0; i < 4; i++) begin
            run_frame(cur, plan[i], 1'b1);
            cur = plan[i];
        end
        for (int i = 0; i < 8; i++) begin
            nxt = rand_cfg();
            run_frame(cur, nxt, 1'b1);
            cur = nxt;
        end
        run_frame(cur, cur, 1'b0);

        done = 1'b1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

endmodule